// File: doc/BRIEF.md
# Burst PPM Transmit Timing Controller

This block converts a serial stream of data bits into start-pulse timing for a pulsed ultra-wideband transmitter that uses binary pulse-position modulation. Every symbol frame is split into two equal slots at its start; a 0 places the energy in the early slot and a 1 in the late slot. Within the selected slot the block fires a burst of pulse triggers on consecutive ticks, one per tick, and it repeats the whole symbol frame a programmable number of times for each bit. It also drives a standby line that lets the analog driver cut leakage between packets.

Bits arrive through a valid/ready handshake together with a flag that marks the last bit of a packet. The burst length, symbol period and repetition count are sampled when a bit is accepted, so a new setting only applies from the next bit boundary. Each trigger is paired with a pulse index so that a downstream phase modulator can line its phase pattern up with the burst.

Top module: `uwb_burst_ppm_ctrl`

## Requirements
- R1: After reset, `standby` is 1, `bit_ready` is 1 and `pulse_strobe` is 0.
- R2: For a bit of value 0, `pulse_strobe` is high on symbol ticks 0 to Np-1, where tick 0 is the first cycle after the bit is accepted.
- R3: For a bit of value 1, `pulse_strobe` is high on symbol ticks SLOT_TICKS to SLOT_TICKS+Np-1.
- R4: With each strobe, `pulse_idx` carries the pulse position inside the burst, counting 0 up to Np-1.
- R5: The symbol frame repeats back to back for the programmed repetition count; a count of 0 is treated as 1.
- R6: A burst length of 0 is treated as 1, and one larger than SLOT_TICKS is cut to SLOT_TICKS.
- R7: A symbol period shorter than 2*SLOT_TICKS ticks is raised to 2*SLOT_TICKS.
- R8: `bit_ready` is low while a bit is being sent, except in its final tick; a bit accepted in that tick starts its frame with no gap.
- R9: Burst length, period, repetition count and bit value are captured at acceptance; input changes while the bit is being sent have no effect on its timing.
- R10: When a bit marked last completes and no bit is accepted in its final tick, `standby` goes to 1 and stays there until the next acceptance; after a bit not marked last it stays 0.
- R11: `standby` is 0 in the cycle after a bit is accepted and throughout its transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | A data bit is offered |
| bit_data | input | 1 | Bit value selecting the slot |
| bit_last | input | 1 | Offered bit ends a packet |
| bit_ready | output | 1 | Block can take a bit this cycle |
| cfg_np | input | NP_W | Pulses per burst |
| cfg_period | input | PER_W | Symbol period in ticks |
| cfg_reps | input | REP_W | Symbol repetitions per bit |
| pulse_strobe | output | 1 | One-tick start-pulse trigger |
| pulse_idx | output | NP_W | Position of the current pulse in its burst |
| standby | output | 1 | Driver standby request |

## Verification
The bench builds the block with a slot of 5 ticks, a 4-bit burst field, an 8-bit period field and a 4-bit repetition field. The short slot keeps every frame small enough that each tick of every repetition is compared, while the 4-bit burst field can hold values above the slot length, which brings the burst clamp within reach. Periods below two slots, zero bursts and zero repetitions exercise the remaining clamps, and a chained bit covers the gapless hand-over in the final tick.

// File: rtl/uwb_ppm_pkg.sv
package uwb_ppm_pkg;

  // Controller operating state
  typedef enum logic [1:0] {
    ST_STBY = 2'd0,
    ST_IDLE = 2'd1,
    ST_RUN  = 2'd2
  } tx_state_e;

endpackage

// File: rtl/uwb_cfg_latch.sv
// Clamps the configuration inputs and captures them with the bit value
// when a bit is accepted.
module uwb_cfg_latch #(
  parameter int SLOT_TICKS = 15,
  parameter int NP_W       = 4,
  parameter int PER_W      = 16,
  parameter int REP_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             bit_in,
  input  logic             last_in,
  input  logic [NP_W-1:0]  np_in,
  input  logic [PER_W-1:0] per_in,
  input  logic [REP_W-1:0] reps_in,
  output logic             bit_q,
  output logic             last_q,
  output logic [NP_W-1:0]  np_q,
  output logic [PER_W-1:0] per_q,
  output logic [REP_W-1:0] reps_q
);

  localparam int MIN_PER = 2 * SLOT_TICKS;

  logic [NP_W-1:0]  np_clamp;
  logic [PER_W-1:0] per_clamp;
  logic [REP_W-1:0] reps_clamp;

  always_comb begin
    if (np_in == '0) begin
      np_clamp = NP_W'(1);
    end else if (np_in > NP_W'(SLOT_TICKS)) begin
      np_clamp = NP_W'(SLOT_TICKS);
    end else begin
      np_clamp = np_in;
    end

    if (per_in < PER_W'(MIN_PER)) begin
      per_clamp = PER_W'(MIN_PER);
    end else begin
      per_clamp = per_in;
    end

    if (reps_in == '0) begin
      reps_clamp = REP_W'(1);
    end else begin
      reps_clamp = reps_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= 1'b0;
      last_q <= 1'b0;
      np_q   <= NP_W'(1);
      per_q  <= PER_W'(MIN_PER);
      reps_q <= REP_W'(1);
    end else if (load) begin
      bit_q  <= bit_in;
      last_q <= last_in;
      np_q   <= np_clamp;
      per_q  <= per_clamp;
      reps_q <= reps_clamp;
    end
  end

endmodule

// File: rtl/uwb_sym_timer.sv
// Tick counter inside a symbol frame and repetition counter across frames.
module uwb_sym_timer #(
  parameter int PER_W = 16,
  parameter int REP_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [PER_W-1:0] per_q,
  input  logic [REP_W-1:0] reps_q,
  output logic [PER_W-1:0] tick,
  output logic             bit_done
);

  logic [PER_W-1:0] tick_q, tick_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             sym_last;
  logic             cnt_en;

  assign sym_last = (tick_q == per_q - PER_W'(1));
  assign bit_done = run && sym_last && (rep_q == reps_q - REP_W'(1));
  assign cnt_en   = start || run;

  always_comb begin
    tick_d = tick_q;
    rep_d  = rep_q;
    if (start) begin
      tick_d = '0;
      rep_d  = '0;
    end else if (run) begin
      if (sym_last) begin
        tick_d = '0;
        rep_d  = rep_q + REP_W'(1);
      end else begin
        tick_d = tick_q + PER_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      rep_q  <= '0;
    end else if (cnt_en) begin
      tick_q <= tick_d;
      rep_q  <= rep_d;
    end
  end

  assign tick = tick_q;

endmodule

// File: rtl/uwb_pulse_map.sv
// Decodes the symbol tick into burst triggers and pulse positions.
module uwb_pulse_map #(
  parameter int SLOT_TICKS = 15,
  parameter int NP_W       = 4,
  parameter int PER_W      = 16
) (
  input  logic             active,
  input  logic             bit_q,
  input  logic [NP_W-1:0]  np_q,
  input  logic [PER_W-1:0] tick,
  output logic             strobe,
  output logic [NP_W-1:0]  idx
);

  logic [PER_W-1:0] slot_base;
  logic [PER_W-1:0] rel;
  logic             in_slot;

  assign slot_base = bit_q ? PER_W'(SLOT_TICKS) : '0;
  assign rel       = tick - slot_base;
  assign in_slot   = (tick >= slot_base) && (rel < PER_W'(np_q));
  assign strobe    = active && in_slot;
  assign idx       = strobe ? rel[NP_W-1:0] : '0;

endmodule

// File: rtl/uwb_burst_ppm_ctrl.sv
// Burst PPM transmit timing controller: top level with handshake and state.
module uwb_burst_ppm_ctrl
  import uwb_ppm_pkg::*;
#(
  parameter int SLOT_TICKS = 15,
  parameter int NP_W       = 4,
  parameter int PER_W      = 16,
  parameter int REP_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_data,
  input  logic             bit_last,
  output logic             bit_ready,
  input  logic [NP_W-1:0]  cfg_np,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [REP_W-1:0] cfg_reps,
  output logic             pulse_strobe,
  output logic [NP_W-1:0]  pulse_idx,
  output logic             standby
);

  // Reset is asserted at once and released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_int = rst_sync_q[1];

  tx_state_e        state_q, state_d;
  logic             accept;
  logic             running;
  logic             bit_done;
  logic             bit_q, last_q;
  logic [NP_W-1:0]  np_q;
  logic [PER_W-1:0] per_q;
  logic [REP_W-1:0] reps_q;
  logic [PER_W-1:0] tick;

  assign running   = (state_q == ST_RUN);
  assign bit_ready = !running || bit_done;
  assign accept    = bit_valid && bit_ready;

  uwb_cfg_latch #(
    .SLOT_TICKS (SLOT_TICKS),
    .NP_W       (NP_W),
    .PER_W      (PER_W),
    .REP_W      (REP_W)
  ) i_cfg (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .load    (accept),
    .bit_in  (bit_data),
    .last_in (bit_last),
    .np_in   (cfg_np),
    .per_in  (cfg_period),
    .reps_in (cfg_reps),
    .bit_q   (bit_q),
    .last_q  (last_q),
    .np_q    (np_q),
    .per_q   (per_q),
    .reps_q  (reps_q)
  );

  uwb_sym_timer #(
    .PER_W (PER_W),
    .REP_W (REP_W)
  ) i_timer (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start    (accept),
    .run      (running),
    .per_q    (per_q),
    .reps_q   (reps_q),
    .tick     (tick),
    .bit_done (bit_done)
  );

  uwb_pulse_map #(
    .SLOT_TICKS (SLOT_TICKS),
    .NP_W       (NP_W),
    .PER_W      (PER_W)
  ) i_map (
    .active (running),
    .bit_q  (bit_q),
    .np_q   (np_q),
    .tick   (tick),
    .strobe (pulse_strobe),
    .idx    (pulse_idx)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_STBY, ST_IDLE: begin
        if (accept) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (bit_done && !accept) begin
          state_d = last_q ? ST_STBY : ST_IDLE;
        end
      end
      default: state_d = ST_STBY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= ST_STBY;
    end else begin
      state_q <= state_d;
    end
  end

  assign standby = (state_q == ST_STBY);

endmodule

// File: rtl/uwb_burst_ppm_ctrl_chk.sv
// Port-level properties of the controller, bound into the top module.
module uwb_burst_ppm_ctrl_chk #(
  parameter int SLOT_TICKS = 15,
  parameter int NP_W       = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bit_valid,
  input logic            bit_ready,
  input logic            pulse_strobe,
  input logic [NP_W-1:0] pulse_idx,
  input logic            standby
);

  AST_STROBE_NOT_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_strobe |-> !standby); // R11

  AST_ACCEPT_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_ready) |=> !standby); // R11

  AST_STANDBY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> bit_ready); // R10

  AST_IDX_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_strobe |-> (int'(pulse_idx) < SLOT_TICKS)); // R6

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_strobe && pulse_idx != '0) |->
      ($past(pulse_strobe) && pulse_idx == $past(pulse_idx) + NP_W'(1))); // R4

endmodule

bind uwb_burst_ppm_ctrl uwb_burst_ppm_ctrl_chk #(
  .SLOT_TICKS (SLOT_TICKS),
  .NP_W       (NP_W)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_valid    (bit_valid),
  .bit_ready    (bit_ready),
  .pulse_strobe (pulse_strobe),
  .pulse_idx    (pulse_idx),
  .standby      (standby)
);

// File: tb/test_uwb_burst_ppm_ctrl.sv
`timescale 1ns/1ps
module test_uwb_burst_ppm_ctrl;

  localparam int SLOT  = 5;
  localparam int NP_W  = 4;
  localparam int PER_W = 8;
  localparam int REP_W = 4;

  logic             clk;
  logic             rst_n;
  logic             bit_valid;
  logic             bit_data;
  logic             bit_last;
  logic             bit_ready;
  logic [NP_W-1:0]  cfg_np;
  logic [PER_W-1:0] cfg_period;
  logic [REP_W-1:0] cfg_reps;
  logic             pulse_strobe;
  logic [NP_W-1:0]  pulse_idx;
  logic             standby;

  int n_tests;
  int n_fail;
  bit done;

  uwb_burst_ppm_ctrl #(
    .SLOT_TICKS (SLOT),
    .NP_W       (NP_W),
    .PER_W      (PER_W),
    .REP_W      (REP_W)
  ) i_uwb_burst_ppm_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_valid    (bit_valid),
    .bit_data     (bit_data),
    .bit_last     (bit_last),
    .bit_ready    (bit_ready),
    .cfg_np       (cfg_np),
    .cfg_period   (cfg_period),
    .cfg_reps     (cfg_reps),
    .pulse_strobe (pulse_strobe),
    .pulse_idx    (pulse_idx),
    .standby      (standby)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Vector: {bit, last, np[3:0], reps[3:0], period[7:0]}
  localparam int NVEC = 7;
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 4'd3, 4'd2, 8'd12},  // R2 R5 two frames
    {1'b1, 1'b0, 4'd2, 4'd3, 8'd10},  // R3 R5 three frames
    {1'b1, 1'b1, 4'd5, 4'd1, 8'd15},  // R3 full slot, ends packet
    {1'b0, 1'b0, 4'd0, 4'd2, 8'd10},  // R6 zero burst
    {1'b1, 1'b0, 4'd9, 4'd1, 8'd11},  // R6 burst above slot
    {1'b0, 1'b0, 4'd2, 4'd0, 8'd10},  // R5 zero repetitions
    {1'b1, 1'b1, 4'd1, 4'd2, 8'd3}    // R7 short period
  };
  localparam string VTAG [NVEC] = '{"R5", "R5", "R3", "R6", "R6", "R5", "R7"};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Offer one bit at the current falling edge and follow its frames tick by tick.
  task automatic send_bit(input bit b, input bit l, input int np, input int reps,
                          input int per, input string tag, input bit scramble,
                          input bit chain);
    int npe, pe, re, total, off, pulses;
    npe = (np == 0) ? 1 : ((np > SLOT) ? SLOT : np);
    pe  = (per < 2 * SLOT) ? 2 * SLOT : per;
    re  = (reps == 0) ? 1 : reps;
    total = re * pe;
    off = b ? SLOT : 0;
    pulses = 0;
    bit_valid  = 1'b1;
    bit_data   = b;
    bit_last   = l;
    cfg_np     = NP_W'(np);
    cfg_reps   = REP_W'(reps);
    cfg_period = PER_W'(per);
    check(bit_ready == 1'b1, "R8", int'(bit_ready), 1);
    @(posedge clk);
    @(negedge clk);
    bit_valid = 1'b0;
    for (int k = 0; k < total; k++) begin
      int t;
      bit exp_s;
      t = k % pe;
      exp_s = (t >= off) && (t < off + npe);
      if (scramble && k == 1) begin
        // R9: new settings during transmission must be ignored
        cfg_np     = NP_W'(1);
        cfg_reps   = REP_W'(7);
        cfg_period = PER_W'(40);
        bit_data   = ~b;
      end
      if (b) check(pulse_strobe == exp_s, scramble ? "R9" : "R3", int'(pulse_strobe), int'(exp_s));
      else   check(pulse_strobe == exp_s, scramble ? "R9" : "R2", int'(pulse_strobe), int'(exp_s));
      if (exp_s) begin
        check(int'(pulse_idx) == t - off, "R4", int'(pulse_idx), t - off);
        pulses++;
      end
      check(bit_ready == (k == total - 1), "R8", int'(bit_ready), int'(k == total - 1));
      check(standby == 1'b0, "R11", int'(standby), 0);
      if (k == total - 1 && chain) begin
        check(pulses == re * npe, tag, pulses, re * npe);
        return;
      end
      @(negedge clk);
    end
    check(pulses == re * npe, tag, pulses, re * npe);
    check(standby == l, "R10", int'(standby), int'(l));
    check(pulse_strobe == 1'b0, "R10", int'(pulse_strobe), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    n_tests = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    bit_valid = 1'b0;
    bit_data = 1'b0;
    bit_last = 1'b0;
    cfg_np = '0;
    cfg_period = '0;
    cfg_reps = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(standby == 1'b1, "R1", int'(standby), 1);
    check(bit_ready == 1'b1, "R1", int'(bit_ready), 1);
    check(pulse_strobe == 1'b0, "R1", int'(pulse_strobe), 0);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [17:0] e;
      e = VEC[v];
      send_bit(e[17], e[16], int'(e[15:12]), int'(e[11:8]), int'(e[7:0]), VTAG[v], 1'b0, 1'b0);
      @(negedge clk);
    end

    // R10: standby holds while nothing is offered after a packet end
    for (int i = 0; i < 5; i++) begin
      check(standby == 1'b1, "R10", int'(standby), 1);
      check(pulse_strobe == 1'b0, "R10", int'(pulse_strobe), 0);
      @(negedge clk);
    end

    // R9: configuration scrambled mid-bit
    send_bit(1'b0, 1'b0, 3, 2, 12, "R9", 1'b1, 1'b0);
    @(negedge clk);

    // R8: chained bits without a gap, second one ends the packet
    send_bit(1'b1, 1'b0, 2, 1, 10, "R8", 1'b0, 1'b1);
    send_bit(1'b0, 1'b1, 1, 1, 10, "R8", 1'b0, 1'b0);
    @(negedge clk);
    check(standby == 1'b1, "R10", int'(standby), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule